// File: doc/BRIEF.md
# Strap-Addressed Two-Wire Target Interface

This block is the target side of an I2C bus. It never drives the clock. It samples both bus lines with the system clock, finds START and STOP conditions, and collects the address byte. It pulls the data line low to acknowledge only when that byte names this device. After the address it moves bytes between the bus and a simple register-access port. In a write, the first data byte selects a register index. Each following byte is written to that index, and the index then advances. In a read, bytes are taken from the current index, also advancing, for as long as the controller keeps acknowledging.

Two strap pins supply the low two bits of the 7-bit device address, so up to four of these devices can share one bus. The upper five bits are fixed by a parameter. The strap levels are captured once, in the first clock after reset is released. After that they are held, and later changes on the pins have no effect. The data line is modelled as an output enable: when the enable is high the pin is pulled low, and when it is low the pin is released.

Top module: `i2c_strap_target`

## Requirements
- R1: While reset is asserted and right after it is released, `sda_oe_o`, `reg_wr_o` and `reg_rd_o` are 0 and `reg_idx_o` is 0.
- R2: The device answers address bytes whose upper seven bits (MSB first) are `1,0,1,1,1,strap[1],strap[0]`. Bit 0 is R/W, where 1 means read. With straps at 00 these bytes are 8'hB8 (write) and 8'hB9 (read). A matching byte is acknowledged by holding SDA low for the ninth clock.
- R3: The strap levels are latched on the first clock after reset release and then held. A later strap change does not alter the answered address until the next reset. For example, after a reset with straps at 10, 8'hBC is acknowledged and 8'hB8 is not.
- R4: After an address that does not match, SDA stays released and no register strobe occurs until the next START or STOP, whatever bytes follow.
- R5: A falling SDA while SCL is high is a START. A rising SDA while SCL is high is a STOP. Either one abandons any partial byte, and a START, including a repeated START, begins a new address phase.
- R6: In a write transfer, the first data byte is acknowledged and loaded into the register index. It causes no write strobe.
- R7: Each later write data byte is acknowledged and gives a one-cycle `reg_wr_o` pulse, with `reg_idx_o` as the target and the byte on `reg_wdata_o`. The index then increments and wraps from 2^IDX_W-1 to 0.
- R8: In a read transfer, each byte is taken from `reg_rdata_i` at the current index. A `reg_rd_o` pulse marks the capture, and the index then increments. The byte is shifted out MSB first. Reading continues while the controller acknowledges. After a NACK, SDA stays released.
- R9: `sda_oe_o` changes only while SCL is low.
- R10: `reg_wr_o` and `reg_rd_o` are never high in the same cycle, and each is high for only one cycle at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| strap_i | input | 2 | Address strap pins, low two address bits |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe_o | output | 1 | 1 pulls the data line low, 0 releases it |
| reg_idx_o | output | IDX_W | Current register index |
| reg_wdata_o | output | 8 | Write data for the register port |
| reg_wr_o | output | 1 | One-cycle write strobe |
| reg_rd_o | output | 1 | One-cycle strobe marking capture of `reg_rdata_i` |
| reg_rdata_i | input | 8 | Read data for `reg_idx_o`, combinational from the register side |

## Verification
The bench builds the block with its defaults: an 8-bit index, two synchronizer stages and high address bits 10111. With an 8-bit index, the wrap from 8'hFF to 8'h00 takes only one index byte and two data bytes, so it is reached directly. With two synchronizer stages, the delay from a bus edge to the slave's response is a few system clocks, well inside a ten-clock quarter bit. This lets the bench check that the acknowledge and data bits settle before SCL rises. A second reset with different strap levels brings a new address into reach and confirms that straps are captured only at reset.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;
  localparam int BYTE_W = 8;
  localparam int BCNT_W = 4;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_WR,
    ST_WR_ACK,
    ST_RD,
    ST_RD_ACK
  } tgt_state_t;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_i,
  output logic level_o,
  output logic rise_o,
  output logic fall_o
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;
  logic              prev_q;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], line_i};
  end

  // bus idles high, so reset to 1
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '1;
      prev_q <= 1'b1;
    end else begin
      sync_q <= sync_d;
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign level_o = sync_q[STAGES-1];
  assign rise_o  = level_o & ~prev_q;
  assign fall_o  = ~level_o & prev_q;
endmodule

// File: rtl/i2c_strap_latch.sv
module i2c_strap_latch (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] strap_i,
  output logic [1:0] strap_o
);
  logic [1:0] strap_q, strap_d;
  logic       taken_q, taken_d;

  always_comb begin
    taken_d = 1'b1;
    strap_d = taken_q ? strap_q : strap_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strap_q <= 2'b00;
      taken_q <= 1'b0;
    end else begin
      strap_q <= strap_d;
      taken_q <= taken_d;
    end
  end

  assign strap_o = strap_q;

  assert_strap_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    taken_q |=> $stable(strap_q));
endmodule

// File: rtl/i2c_strap_target.sv
module i2c_strap_target
  import i2c_tgt_pkg::*;
#(
  parameter int         IDX_W       = 8,
  parameter int         SYNC_STAGES = 2,
  parameter logic [4:0] ADDR_HI     = 5'b10111
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        strap_i,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe_o,
  output logic [IDX_W-1:0]  reg_idx_o,
  output logic [BYTE_W-1:0] reg_wdata_o,
  output logic              reg_wr_o,
  output logic              reg_rd_o,
  input  logic [BYTE_W-1:0] reg_rdata_i
);
  localparam int NLINES = 2;
  localparam logic [BCNT_W-1:0] FULL = BCNT_W'(BYTE_W);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rs_q;
  logic       rst_ni;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_ni = rs_q[1];

  // bus line synchronizers: index 0 = SCL, 1 = SDA
  logic [NLINES-1:0] line_in, lvl, rise, fall;
  assign line_in = {sda_i, scl_i};
  for (genvar g = 0; g < NLINES; g++) begin : g_line
    i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_ni), .line_i(line_in[g]),
      .level_o(lvl[g]), .rise_o(rise[g]), .fall_o(fall[g])
    );
  end

  logic scl_lvl, scl_rise, scl_fall, sda_lvl, start_ev, stop_ev;
  assign scl_lvl  = lvl[0];
  assign scl_rise = rise[0];
  assign scl_fall = fall[0];
  assign sda_lvl  = lvl[1];
  assign start_ev = fall[1] & scl_lvl;
  assign stop_ev  = rise[1] & scl_lvl;

  logic [1:0] strap;
  i2c_strap_latch u_strap (.clk(clk), .rst_n(rst_ni), .strap_i(strap_i), .strap_o(strap));

  tgt_state_t        state_q, state_d;
  logic [BCNT_W-1:0] bcnt_q, bcnt_d;
  logic [BYTE_W-1:0] sh_q, sh_d, wdata_q, wdata_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic              oe_q, oe_d, rw_q, rw_d, first_q, first_d;
  logic              inc_q, inc_d, mack_q, mack_d, wr_q, wr_d, rd_q, rd_d;
  logic              load_rd;
  logic              addr_hit;

  assign addr_hit = (sh_q[7:1] == {ADDR_HI, strap});

  always_comb begin
    state_d = state_q; bcnt_d = bcnt_q; sh_d = sh_q; wdata_d = wdata_q;
    idx_d = idx_q; oe_d = oe_q; rw_d = rw_q; first_d = first_q;
    inc_d = inc_q; mack_d = mack_q; wr_d = 1'b0; rd_d = 1'b0;
    load_rd = 1'b0;
    if (start_ev) begin
      state_d = ST_ADDR; bcnt_d = '0; oe_d = 1'b0;
    end else if (stop_ev) begin
      state_d = ST_IDLE; oe_d = 1'b0;
    end else begin
      unique case (state_q)
        ST_ADDR: begin
          if (scl_rise) begin
            sh_d = {sh_q[BYTE_W-2:0], sda_lvl}; bcnt_d = bcnt_q + 1'b1;
          end else if (scl_fall && bcnt_q == FULL) begin
            if (addr_hit) begin
              state_d = ST_ADDR_ACK; oe_d = 1'b1; rw_d = sh_q[0]; first_d = 1'b1;
            end else begin
              state_d = ST_IDLE;
            end
          end
        end
        ST_ADDR_ACK: begin
          if (scl_fall) begin
            if (rw_q) begin
              load_rd = 1'b1;
            end else begin
              state_d = ST_WR; oe_d = 1'b0; bcnt_d = '0;
            end
          end
        end
        ST_WR: begin
          if (scl_rise) begin
            sh_d = {sh_q[BYTE_W-2:0], sda_lvl}; bcnt_d = bcnt_q + 1'b1;
          end else if (scl_fall && bcnt_q == FULL) begin
            state_d = ST_WR_ACK; oe_d = 1'b1;
            if (first_q) begin
              idx_d = IDX_W'(sh_q); first_d = 1'b0;
            end else begin
              wr_d = 1'b1; wdata_d = sh_q; inc_d = 1'b1;
            end
          end
        end
        ST_WR_ACK: begin
          if (scl_fall) begin
            state_d = ST_WR; oe_d = 1'b0; bcnt_d = '0;
            if (inc_q) begin
              idx_d = idx_q + 1'b1; inc_d = 1'b0;
            end
          end
        end
        ST_RD: begin
          if (scl_rise) begin
            bcnt_d = bcnt_q + 1'b1;
          end else if (scl_fall) begin
            if (bcnt_q == FULL) begin
              state_d = ST_RD_ACK; oe_d = 1'b0;
            end else begin
              sh_d = {sh_q[BYTE_W-2:0], 1'b0}; oe_d = ~sh_q[BYTE_W-2];
            end
          end
        end
        ST_RD_ACK: begin
          if (scl_rise) begin
            mack_d = ~sda_lvl;
          end else if (scl_fall) begin
            if (mack_q) load_rd = 1'b1;
            else state_d = ST_IDLE;
          end
        end
        default: ;
      endcase
    end
    if (load_rd) begin
      state_d = ST_RD; sh_d = reg_rdata_i; oe_d = ~reg_rdata_i[BYTE_W-1];
      rd_d = 1'b1; idx_d = idx_q + 1'b1; bcnt_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE; bcnt_q <= '0; sh_q <= '0; wdata_q <= '0;
      idx_q <= '0; oe_q <= 1'b0; rw_q <= 1'b0; first_q <= 1'b0;
      inc_q <= 1'b0; mack_q <= 1'b0; wr_q <= 1'b0; rd_q <= 1'b0;
    end else begin
      state_q <= state_d; bcnt_q <= bcnt_d; sh_q <= sh_d; wdata_q <= wdata_d;
      idx_q <= idx_d; oe_q <= oe_d; rw_q <= rw_d; first_q <= first_d;
      inc_q <= inc_d; mack_q <= mack_d; wr_q <= wr_d; rd_q <= rd_d;
    end
  end

  assign sda_oe_o    = oe_q;
  assign reg_idx_o   = idx_q;
  assign reg_wdata_o = wdata_q;
  assign reg_wr_o    = wr_q;
  assign reg_rd_o    = rd_q;

  assert_idle_released_R4: assert property (@(posedge clk) disable iff (!rst_ni)
    (state_q == ST_IDLE) |-> !oe_q);
  assert_addr_ack_low_R2: assert property (@(posedge clk) disable iff (!rst_ni)
    (state_q == ST_ADDR_ACK) |-> oe_q);
  assert_oe_on_low_R9: assert property (@(posedge clk) disable iff (!rst_ni)
    $rose(oe_q) |-> !scl_lvl);
  assert_wr_single_R10: assert property (@(posedge clk) disable iff (!rst_ni)
    wr_q |=> !wr_q);
  assert_rd_single_R10: assert property (@(posedge clk) disable iff (!rst_ni)
    rd_q |=> !rd_q);
  assert_strobe_excl_R10: assert property (@(posedge clk) disable iff (!rst_ni)
    !(wr_q && rd_q));
endmodule

// File: tb/tb_i2c_strap_target.sv
module tb_i2c_strap_target;
  localparam int CLK_PERIOD = 10;
  localparam int Q = 10;
  localparam int WD_CYCLES = 180000;
  localparam int NVEC = 8;
  // {address byte, expect ACK}, straps at 00
  localparam logic [8:0] VEC [NVEC] = '{
    {8'hB8, 1'b1}, {8'hB9, 1'b1}, {8'hBA, 1'b0}, {8'hBC, 1'b0},
    {8'hBF, 1'b0}, {8'h38, 1'b0}, {8'hB0, 1'b0}, {8'hF8, 1'b0}
  };

  logic clk = 1'b0;
  logic rst_n;
  logic [1:0] strap;
  logic m_scl, m_sda;
  logic sda_oe;
  logic [7:0] reg_idx, reg_wdata, reg_rdata;
  logic reg_wr, reg_rd;
  logic sda_bus;
  logic [7:0] mem [256];

  int checks = 0, failures = 0, cyc = 0;
  int wr_cnt = 0, rd_cnt = 0, viol9 = 0, viol10 = 0;
  logic prev_oe = 1'b0, prev_wr = 1'b0, prev_rd = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign sda_bus   = m_sda & ~sda_oe;
  assign reg_rdata = mem[reg_idx];

  i2c_strap_target dut (
    .clk(clk), .rst_n(rst_n), .strap_i(strap), .scl_i(m_scl), .sda_i(sda_bus),
    .sda_oe_o(sda_oe), .reg_idx_o(reg_idx), .reg_wdata_o(reg_wdata),
    .reg_wr_o(reg_wr), .reg_rd_o(reg_rd), .reg_rdata_i(reg_rdata)
  );

  always @(posedge clk) begin
    if (reg_wr) begin mem[reg_idx] <= reg_wdata; wr_cnt++; end
    if (reg_rd) rd_cnt++;
    if (rst_n) begin
      if (sda_oe != prev_oe && m_scl) viol9++;
      if ((reg_wr && reg_rd) || (reg_wr && prev_wr) || (reg_rd && prev_rd)) viol10++;
    end
    prev_oe <= sda_oe; prev_wr <= reg_wr; prev_rd <= reg_rd;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == WD_CYCLES) begin
      failures++;
      $display("FAIL watchdog act=%0d exp=<%0d", cyc, WD_CYCLES);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wq(); repeat (Q) @(negedge clk); endtask
  task automatic bus_start(); m_sda = 1'b0; wq(); m_scl = 1'b0; wq(); endtask
  task automatic bus_rstart(); m_sda = 1'b1; wq(); m_scl = 1'b1; wq(); m_sda = 1'b0; wq(); m_scl = 1'b0; wq(); endtask
  task automatic bus_stop(); m_sda = 1'b0; wq(); m_scl = 1'b1; wq(); m_sda = 1'b1; wq(); endtask
  task automatic send_bit(input logic b); m_sda = b; wq(); m_scl = 1'b1; wq(); wq(); m_scl = 1'b0; wq(); endtask
  task automatic recv_bit(output logic b); m_sda = 1'b1; wq(); m_scl = 1'b1; wq(); b = sda_bus; wq(); m_scl = 1'b0; wq(); endtask

  task automatic send_byte(input logic [7:0] v, output logic ack);
    logic a;
    for (int i = 7; i >= 0; i--) send_bit(v[i]);
    recv_bit(a);
    ack = ~a;
  endtask

  task automatic recv_byte(input logic give_ack, output logic [7:0] v);
    for (int i = 7; i >= 0; i--) recv_bit(v[i]);
    send_bit(~give_ack);
  endtask

  task automatic do_reset(input logic [1:0] s);
    strap = s; rst_n = 1'b0;
    repeat (5) @(negedge clk);
    chk("R1 oe in reset", 32'(sda_oe), 32'd0);
    chk("R1 strobes in reset", 32'({reg_wr, reg_rd}), 32'd0);
    chk("R1 idx in reset", 32'(reg_idx), 32'd0);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  initial begin
    logic ack;
    logic [7:0] d;
    int w0;
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    m_scl = 1'b1; m_sda = 1'b1;
    do_reset(2'b00);
    chk("R1 oe after release", 32'(sda_oe), 32'd0);

    // address table walk (R2)
    for (int i = 0; i < NVEC; i++) begin
      bus_start();
      send_byte(VEC[i][8:1], ack);
      chk($sformatf("R2 addr %h ack", VEC[i][8:1]), 32'(ack), 32'(VEC[i][0]));
      if (ack && VEC[i][1]) recv_byte(1'b0, d);
      bus_stop();
    end

    // write with index and auto-increment (R6, R7)
    w0 = wr_cnt;
    bus_start(); send_byte(8'hB8, ack);
    send_byte(8'h10, ack); chk("R6 index byte ack", 32'(ack), 32'd1);
    chk("R6 index loaded", 32'(reg_idx), 32'h10);
    chk("R6 no write strobe", 32'(wr_cnt - w0), 32'd0);
    send_byte(8'hA1, ack); chk("R7 data ack", 32'(ack), 32'd1);
    send_byte(8'hB2, ack);
    send_byte(8'h3C, ack);
    bus_stop();
    chk("R7 write count", 32'(wr_cnt - w0), 32'd3);
    chk("R7 mem 10", 32'(mem[8'h10]), 32'hA1);
    chk("R7 mem 11", 32'(mem[8'h11]), 32'hB2);
    chk("R7 mem 12", 32'(mem[8'h12]), 32'h3C);

    // read via repeated start (R8, R5)
    w0 = rd_cnt;
    bus_start(); send_byte(8'hB8, ack); send_byte(8'h10, ack);
    bus_rstart(); send_byte(8'hB9, ack);
    chk("R5 repeated start address ack", 32'(ack), 32'd1);
    recv_byte(1'b1, d); chk("R8 read byte 0", 32'(d), 32'hA1);
    recv_byte(1'b1, d); chk("R8 read byte 1", 32'(d), 32'hB2);
    recv_byte(1'b0, d); chk("R8 read byte 2", 32'(d), 32'h3C);
    chk("R8 released after nack", 32'(sda_oe), 32'd0);
    bus_stop();
    chk("R8 read strobes", 32'(rd_cnt - w0), 32'd3);

    // index wrap (R7)
    bus_start(); send_byte(8'hB8, ack); send_byte(8'hFF, ack);
    send_byte(8'h5A, ack); send_byte(8'h6B, ack); bus_stop();
    chk("R7 wrap mem FF", 32'(mem[8'hFF]), 32'h5A);
    chk("R7 wrap mem 00", 32'(mem[8'h00]), 32'h6B);

    // mismatch followed by data (R4)
    w0 = wr_cnt;
    bus_start(); send_byte(8'hBA, ack);
    send_byte(8'h20, ack); chk("R4 no ack on data after miss", 32'(ack), 32'd0);
    send_byte(8'h77, ack); chk("R4 still released", 32'(ack), 32'd0);
    bus_stop();
    chk("R4 no write strobe", 32'(wr_cnt - w0), 32'd0);

    // aborted byte (R5)
    w0 = wr_cnt;
    bus_start(); send_byte(8'hB8, ack); send_byte(8'h30, ack);
    for (int i = 0; i < 4; i++) send_bit(1'b1);
    bus_stop();
    chk("R5 partial byte dropped", 32'(wr_cnt - w0), 32'd0);
    chk("R5 mem untouched", 32'(mem[8'h30]), 32'h00);
    bus_start(); send_byte(8'hB8, ack);
    chk("R5 new transfer acks", 32'(ack), 32'd1);
    bus_stop();

    // strap change without reset (R3)
    strap = 2'b11;
    repeat (4) @(negedge clk);
    bus_start(); send_byte(8'hBE, ack); bus_stop();
    chk("R3 new strap ignored", 32'(ack), 32'd0);
    bus_start(); send_byte(8'hB8, ack); bus_stop();
    chk("R3 latched address kept", 32'(ack), 32'd1);

    // fresh reset with straps 10 (R3, R1)
    do_reset(2'b10);
    strap = 2'b00;
    bus_start(); send_byte(8'hBC, ack); bus_stop();
    chk("R3 strap 10 address acks", 32'(ack), 32'd1);
    bus_start(); send_byte(8'hB8, ack); bus_stop();
    chk("R3 old address refused", 32'(ack), 32'd0);

    chk("R9 oe moved with SCL high", 32'(viol9), 32'd0);
    chk("R10 strobe overlap", 32'(viol10), 32'd0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule